// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a voltage-output DAC. A host writes 16-bit command words over a three-wire link: an active-low chip select, a serial clock and a data line. The block runs on its own system clock. It passes the three serial lines through two-flop synchronisers and detects the falling edges of the serial clock. It shifts the data in MSB first and latches the word by itself on the sixteenth falling edge. After that, it ignores further clocks until chip select has gone high and low again.

The top four bits of a latched word form a control code. Code 0000 writes the data field into the DAC code register. Code 1111 selects the output mode from the two lowest bits of the word. A parameter picks 12, 10 or 8 bit resolution. The data field always ends at bit 11, so narrower parts drop the low bits, and those low bits then serve only as mode bits. The block drives the DAC code, a 2-bit output mode and a one-cycle update strobe.

Top module: `sdac_cmd_if`

## Requirements
- R1: Data is sampled MSB first on each falling edge of the serial clock while chip select is low. Bit 15 is the first bit sent.
- R2: While chip select is high, the serial clock has no effect and the bit counter clears. A frame that ends with chip select high before 16 falling edges changes no output.
- R3: The word latches on the 16th falling edge. Any further falling edges in the same frame are ignored until chip select returns high and then goes low again.
- R4: Control code 0000 in bits [15:12] loads the data field into the DAC code and leaves the output mode unchanged.
- R5: Control code 1111 sets the output mode from bits [1:0] and leaves the DAC code unchanged. The modes are 00 driven (wake-up), 01 floating, 10 1 kOhm termination and 11 100 kOhm termination.
- R6: Any other control code changes neither the DAC code nor the output mode.
- R7: After reset the DAC code is zero, the output mode is 00 and the update strobe is low.
- R8: update_o pulses high for exactly one system clock for each accepted 0000 or 1111 command, in the cycle in which the new value appears. It stays low at all other times.
- R9: The data field is bits [11:0] at 12-bit resolution, bits [11:2] at 10-bit and bits [11:4] at 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | RES_BITS | DAC code register |
| out_mode_o | output | 2 | Output mode: 00 driven, 01 float, 10 1k, 11 100k |
| update_o | output | 1 | One-cycle strobe on an accepted command |

## Verification
A counter that is out of step with the link shows up at once. The next frame latches a word one or more bits off, so the DAC code comes out shifted or carries the wrong control code, within four system clocks of the 16th edge. A lockout flag that stays set drops the whole next frame: the code and the update count stay put. A lockout flag that clears too early lets a 17th edge form a second command, which shows as an extra update pulse. Wrong field extraction at one resolution shows only on that build. The bench therefore runs 12, 10 and 8 bit instances side by side from the same serial lines.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;
  localparam int CTRL_MSB = 15;
  localparam int CTRL_LSB = 12;
  localparam int FIELD_MSB = 11;
  localparam logic [3:0] CTRL_LOAD = 4'h0;
  localparam logic [3:0] CTRL_PWR  = 4'hF;

  typedef enum logic [1:0] {
    MODE_DRIVE   = 2'b00,
    MODE_FLOAT   = 2'b01,
    MODE_TERM_LO = 2'b10,
    MODE_TERM_HI = 2'b11
  } out_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
  import sdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d_q;
  logic              fall;
  logic [CNT_W-1:0]  cnt_q;
  logic              lock_q;
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] next_sr;

  assign fall    = sclk_d_q && !sclk_i;
  assign next_sr = {sr_q[WORD_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      lock_q     <= 1'b0;
      sr_q       <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (cs_n_i) begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end else if (fall && !lock_q) begin
        sr_q <= next_sr;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          lock_q     <= 1'b1;
          word_o     <= next_sr;
          word_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_cs_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (cnt_q == '0 && !lock_q));
  assert_single_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
  assert_lockout_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !cs_n_i) |=> !word_vld_o);
endmodule

// File: rtl/sdac_cmd.sv
module sdac_cmd
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                word_vld_i,
  output logic [RES_BITS-1:0] code_o,
  output logic [1:0]          mode_o,
  output logic                update_o
);
  logic [3:0] ctrl;
  logic [RES_BITS-1:0] field;

  assign ctrl  = word_i[CTRL_MSB:CTRL_LSB];
  assign field = word_i[FIELD_MSB -: RES_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= '0;
      mode_o   <= MODE_DRIVE;
      update_o <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (word_vld_i) begin
        if (ctrl == CTRL_LOAD) begin
          code_o   <= field;
          update_o <= 1'b1;
        end else if (ctrl == CTRL_PWR) begin
          mode_o   <= word_i[1:0];
          update_o <= 1'b1;
        end
      end
    end
  end

  assert_strobe_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(word_vld_i));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> ($stable(code_o) && $stable(mode_o) && !update_o));
  assert_mode_only_pwr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && ctrl != CTRL_PWR) |=> $stable(mode_o));
  assert_code_only_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && ctrl != CTRL_LOAD) |=> $stable(code_o));
endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [1:0]          out_mode_o,
  output logic                update_o
);
  logic [2:0]        sync_q;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  initial begin
    assert_res_legal_R9: assert (RES_BITS == 12 || RES_BITS == 10 || RES_BITS == 8);
  end

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );

  sdac_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (sync_q[2]),
    .sclk_i    (sync_q[1]),
    .sdi_i     (sync_q[0]),
    .word_o    (word),
    .word_vld_o(word_vld)
  );

  sdac_cmd #(.RES_BITS(RES_BITS)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word),
    .word_vld_i(word_vld),
    .code_o    (dac_code_o),
    .mode_o    (out_mode_o),
    .update_o  (update_o)
  );
endmodule

// File: tb/tb_sdac_cmd_if.sv
module tb_sdac_cmd_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;

  logic [11:0] code12;
  logic [9:0]  code10;
  logic [7:0]  code8;
  logic [1:0]  mode12, mode10, mode8;
  logic        upd12, upd10, upd8;

  int checks = 0;
  int errors = 0;
  int pulses12 = 0, pulses10 = 0, pulses8 = 0;
  int exp_pulses = 0;
  logic [11:0] exp_field = '0;
  logic [1:0]  exp_mode = 2'b00;

  always #10 clk = ~clk;

  sdac_cmd_if #(.RES_BITS(12)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code12), .out_mode_o(mode12), .update_o(upd12));
  sdac_cmd_if #(.RES_BITS(10)) dut10 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code10), .out_mode_o(mode10), .update_o(upd10));
  sdac_cmd_if #(.RES_BITS(8)) dut8 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code8), .out_mode_o(mode8), .update_o(upd8));

  always @(negedge clk) begin
    if (upd12) pulses12++;
    if (upd10) pulses10++;
    if (upd8)  pulses8++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model: bits [11:0] of the last load word; field per resolution is a right shift
  function automatic int field_of(input logic [11:0] f, input int res);
    return int'(f >> (12 - res));
  endfunction

  task automatic check_all(input string req);
    chk({req, " code12 R9"}, int'(code12), field_of(exp_field, 12));
    chk({req, " code10 R9"}, int'(code10), field_of(exp_field, 10));
    chk({req, " code8 R9"},  int'(code8),  field_of(exp_field, 8));
    chk({req, " mode R5"}, int'(mode12), int'(exp_mode));
    chk({req, " mode10 R5"}, int'(mode10), int'(exp_mode));
    chk({req, " mode8 R5"}, int'(mode8), int'(exp_mode));
    chk({req, " pulses R8"}, pulses12, exp_pulses);
    chk({req, " pulses10 R8"}, pulses10, exp_pulses);
    chk({req, " pulses8 R8"}, pulses8, exp_pulses);
  endtask

  task automatic send(input logic [15:0] w, input int nclk, input logic [15:0] extra);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15 - i] : extra[i % 16];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nclk >= 16) begin
      if (w[15:12] == 4'h0) begin
        exp_field = w[11:0];
        exp_pulses++;
      end else if (w[15:12] == 4'hF) begin
        exp_mode = w[1:0];
        exp_pulses++;
      end
    end
  endtask

  initial begin
    int n;
    logic [15:0] w;
    logic [3:0] c;
    void'($urandom(32'h5DAC));
    repeat (3) @(negedge clk);
    check_all("reset R7");
    chk("reset update R7", int'(upd12), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4: MSB first, asymmetric pattern
    send(16'h0A53, 16, 16'h0);
    check_all("load R1 R4");
    // R5: every power mode, code retained
    send(16'hF001, 16, 16'h0); check_all("float R5");
    send(16'hF002, 16, 16'h0); check_all("1k R5");
    send(16'hF003, 16, 16'h0); check_all("100k R5");
    send(16'hF000, 16, 16'h0); check_all("wake R5");
    // R4: load with low bits set leaves mode alone
    send(16'h0FFF, 16, 16'h0); check_all("load keeps mode R4");
    // R6: other control code
    send(16'h7123, 16, 16'h0); check_all("bad ctrl R6");
    // R2: short frame discarded
    send(16'h0555, 15, 16'h0); check_all("short frame R2");
    // R2: clocks while cs high
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    check_all("cs high clocks R2");
    // R3: extra clocks after the 16th ignored
    send(16'h0123, 32, 16'h0FFF); check_all("lockout R3");
    send(16'hF002, 24, 16'hFFFF); check_all("lockout pwr R3");
    // R9 boundaries
    send(16'h0000, 16, 16'h0); check_all("zero R9");
    send(16'h0FFF, 16, 16'h0); check_all("full R9");

    for (int k = 0; k < 60; k++) begin
      n = $urandom_range(0, 9);
      c = (n < 4) ? 4'h0 : (n < 7) ? 4'hF : 4'($urandom_range(0, 15));
      w = {c, 12'($urandom())};
      n = $urandom_range(0, 9);
      send(w, (n == 0) ? $urandom_range(1, 15) : (n == 1) ? $urandom_range(17, 30) : 16,
           16'($urandom()));
      check_all("random R1 R4 R5 R6");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule